// File: doc/BRIEF.md
# Serial Link Word Framer

This block carries fixed 56-bit network words over a 16-bit serializer/deserializer port, in both directions. On the internal side, words are never pushed. The transmit path takes a word only in the cycle it asserts its take strobe against an offered word. The receive path presents a rebuilt word with a ready flag and holds it until the consumer reads it.

Each word travels as a 64-bit frame made of four consecutive 16-bit link words. Eight of the 64 bits protect the top byte of the payload. That byte is split into two nibbles, each covered by a (7,4) Hamming code, so single-bit damage in either nibble or its check bits is repaired on receipt. When the transmitter is not sending a frame, it drives a comma/idle symbol with data-enable low, and it always leaves at least one such symbol between frames. The receiver restarts its frame count on every comma. Each delivered word carries a 3-bit status code.

Top module: `lnk_word_framer`

## Requirements
- R1: `tx_take_o` is high only in a cycle where `tx_avail_i` is high and no frame is being sent; the word on `tx_word_i` in that cycle is the one transmitted.
- R2: In the four cycles after a take, `ser_txen_o` is 1 and `ser_txd_o` carries, in order, payload bits [15:0], [31:16], [47:32], then {payload[55:48], check byte}.
- R3: The check byte holds the Hamming parity of payload[55:52] in bits [7:5] and of payload[51:48] in bits [4:2], with bits [1:0] zero. For a nibble d, the 3-bit parity is {d1^d2^d3, d0^d2^d3, d0^d1^d3}.
- R4: In every cycle without frame data, `ser_txen_o` is 0 and `ser_txd_o` is the idle symbol 16'h50BC; at least one such cycle separates consecutive frames.
- R5: Four consecutive data-valid link words received while the link is up form one word; `rx_rdy_o` rises the cycle after the fourth, and `rx_word_o` is the payload in the R2 layout.
- R6: A comma (data-valid low) arriving in the middle of a frame discards the partial frame, and counting restarts with the next data-valid word.
- R7: While `rx_rdy_o` is high and `rx_read_i` is low, `rx_word_o` and `rx_stat_o` stay unchanged; a read clears `rx_rdy_o` in the next cycle.
- R8: A frame that completes while an unread word is held, with no read in that cycle, is dropped. The next word delivered after that reports status 3'b011.
- R9: A single-bit error in the top payload byte or in check bits [7:2] is corrected in `rx_word_o`, and the word reports status 3'b010.
- R10: A word with a code error flagged on any of its four link words, and no Hamming mismatch, reports status 3'b001.
- R11: A word whose check bits [1:0] are not zero reports status 3'b011.
- R12: A clean word reports status 3'b000. Delivered status is never above 3'b011, and the priority is 011 over 010 over 001.
- R13: While the link indicator is low, received link words are ignored and any partial frame is dropped. While no word is held and the link is down, `rx_stat_o` reads 3'b100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_avail_i | input | 1 | A transmit word is offered |
| tx_word_i | input | 56 | Offered transmit word |
| tx_take_o | output | 1 | Framer takes the offered word this cycle |
| ser_txd_o | output | 16 | Link word to the serializer |
| ser_txen_o | output | 1 | Data enable; low sends the idle/comma symbol |
| ser_rxd_i | input | 16 | Link word from the deserializer |
| ser_rxdv_i | input | 1 | Received data valid; low means comma/idle |
| ser_rxerr_i | input | 1 | Line code error on this received link word |
| ser_link_i | input | 1 | Link/signal present |
| rx_rdy_o | output | 1 | A received word is waiting |
| rx_word_o | output | 56 | Received word |
| rx_stat_o | output | 3 | Status of the waiting word, or link state |
| rx_read_i | input | 1 | Consumer reads the waiting word |

## Verification
The bench loops the transmitter into the receiver and sweeps all 256 values of the protected byte. It flips each of the 16 bits of the fourth link word in turn and injects code errors on every frame position. A wrong parity formula or a swapped nibble would return the wrong byte or report 010 on clean words. Flipping one of the two reserved bits must give 011 with the payload intact; a design that ignored those bits would report 000. Directly driven sequences cover the remaining corner cases:
- a comma after two link words, which a receiver that fails to restart would misalign into the next word;
- a second and third word arriving while the first is unread, where a receiver that overwrites the held word, or forgets the loss, would show the wrong word or status 000;
- a link drop mid-frame, which must both discard the half frame and read 100 when no word is waiting.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

  localparam int unsigned NIB_W      = 4;
  localparam int unsigned CHK_W      = 3;
  localparam int unsigned KEY_GROUPS = 2;
  localparam int unsigned PROT_W     = 8;
  localparam int unsigned RESV_W     = PROT_W - KEY_GROUPS * CHK_W;

  typedef enum logic [2:0] {
    ST_OK     = 3'b000,
    ST_CODE   = 3'b001,
    ST_FIXED  = 3'b010,
    ST_FATAL  = 3'b011,
    ST_NOLINK = 3'b100
  } lnk_stat_e;

  typedef struct packed {
    logic [NIB_W-1:0] nib;
    logic             hit;
  } ham_fix_t;

  // Parity triple {p4, p2, p1} for a nibble placed at code positions 3,5,6,7.
  function automatic logic [CHK_W-1:0] ham_par(input logic [NIB_W-1:0] d);
    logic [CHK_W-1:0] p;
    p[0] = d[0] ^ d[1] ^ d[3];
    p[1] = d[0] ^ d[2] ^ d[3];
    p[2] = d[1] ^ d[2] ^ d[3];
    return p;
  endfunction

  function automatic ham_fix_t ham_fix(input logic [NIB_W-1:0] d,
                                       input logic [CHK_W-1:0] p);
    logic [CHK_W-1:0] syn;
    ham_fix_t         r;
    syn   = ham_par(d) ^ p;
    r.nib = d;
    r.hit = (syn != '0);
    case (syn)
      3'd3:    r.nib[0] = ~d[0];
      3'd5:    r.nib[1] = ~d[1];
      3'd6:    r.nib[2] = ~d[2];
      3'd7:    r.nib[3] = ~d[3];
      default: r.nib = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lnk_tx_seq.sv
module lnk_tx_seq
  import lnk_pkg::*;
#(
  parameter int unsigned PAYLOAD_W = 56,
  parameter int unsigned LANE_W    = 16,
  parameter int unsigned IDLE_SYM  = 'h50BC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 avail_i,
  input  logic [PAYLOAD_W-1:0] word_i,
  output logic                 take_o,
  output logic [LANE_W-1:0]    txd_o,
  output logic                 txen_o
);

  localparam int unsigned FRAME_W = PAYLOAD_W + PROT_W;
  localparam int unsigned FRAMES  = FRAME_W / LANE_W;
  localparam int unsigned IDX_W   = $clog2(FRAMES);
  localparam int unsigned HI_W    = LANE_W - PROT_W;
  localparam int unsigned LO_W    = PAYLOAD_W - HI_W;

  logic [PROT_W-1:0]  prot;
  logic [FRAME_W-1:0] frame_d, frame_q;
  logic               busy_d, busy_q;
  logic [IDX_W-1:0]   idx_d, idx_q;
  logic [LANE_W-1:0]  lane [FRAMES];

  // R3: check byte, one parity triple per key nibble, reserved bits zero
  for (genvar g = 0; g < KEY_GROUPS; g++) begin : g_par
    assign prot[PROT_W-1-g*CHK_W -: CHK_W] =
      ham_par(word_i[PAYLOAD_W-1-g*NIB_W -: NIB_W]);
  end
  assign prot[RESV_W-1:0] = '0;

  // R2: top payload byte shares the last link word with the check byte
  assign frame_d = {word_i[PAYLOAD_W-1 -: HI_W], prot, word_i[LO_W-1:0]};

  for (genvar k = 0; k < FRAMES; k++) begin : g_lane
    assign lane[k] = frame_q[k*LANE_W +: LANE_W];
  end

  always_comb begin
    take_o = avail_i & ~busy_q;
    busy_d = busy_q;
    idx_d  = idx_q;
    if (take_o) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end else if (busy_q) begin
      if (idx_q == IDX_W'(FRAMES - 1)) busy_d = 1'b0;
      idx_d = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take_o) frame_q <= frame_d;
  end

  assign txen_o = busy_q;
  assign txd_o  = busy_q ? lane[idx_q] : LANE_W'(IDLE_SYM);

endmodule

// File: rtl/lnk_rx_asm.sv
module lnk_rx_asm
  import lnk_pkg::*;
#(
  parameter int unsigned PAYLOAD_W = 56,
  parameter int unsigned LANE_W    = 16
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [LANE_W-1:0]                  rxd_i,
  input  logic                               dv_i,
  input  logic                               err_i,
  input  logic                               link_i,
  output logic                               done_o,
  output logic [PAYLOAD_W+PROT_W-1:0]        frame_o,
  output logic                               code_err_o
);

  localparam int unsigned FRAME_W = PAYLOAD_W + PROT_W;
  localparam int unsigned FRAMES  = FRAME_W / LANE_W;
  localparam int unsigned IDX_W   = $clog2(FRAMES);
  localparam int unsigned ACC_W   = FRAME_W - LANE_W;

  logic [IDX_W-1:0] idx_d, idx_q;
  logic             err_d, err_q;
  logic [ACC_W-1:0] acc_q;
  logic             take, last, store_en;

  // R13: nothing is counted while the link is down
  assign take     = link_i & dv_i;
  assign last     = (idx_q == IDX_W'(FRAMES - 1));
  assign store_en = take & ~last;

  assign done_o     = take & last;
  assign frame_o    = {rxd_i, acc_q};
  assign code_err_o = err_q | err_i;

  always_comb begin
    idx_d = idx_q;
    err_d = err_q;
    if (!take || last) begin
      // R6: comma, link loss or a finished frame restart the count
      idx_d = '0;
      err_d = 1'b0;
    end else begin
      idx_d = idx_q + 1'b1;
      err_d = err_q | err_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
      err_q <= 1'b0;
    end else begin
      idx_q <= idx_d;
      err_q <= err_d;
    end
  end

  for (genvar k = 0; k < FRAMES - 1; k++) begin : g_slot
    always_ff @(posedge clk) begin
      if (store_en && idx_q == IDX_W'(k)) acc_q[k*LANE_W +: LANE_W] <= rxd_i;
    end
  end

endmodule

// File: rtl/lnk_rx_dec.sv
module lnk_rx_dec
  import lnk_pkg::*;
#(
  parameter int unsigned PAYLOAD_W = 56,
  parameter int unsigned LANE_W    = 16
) (
  input  logic [PAYLOAD_W+PROT_W-1:0] frame_i,
  output logic [PAYLOAD_W-1:0]        payload_o,
  output logic                        fix_o,
  output logic                        resv_bad_o
);

  localparam int unsigned HI_W  = LANE_W - PROT_W;
  localparam int unsigned LO_W  = PAYLOAD_W - HI_W;
  localparam int unsigned KEY_W = KEY_GROUPS * NIB_W;

  logic [PROT_W-1:0]     prot;
  logic [PAYLOAD_W-1:0]  raw;
  logic [KEY_GROUPS-1:0] hit;

  assign prot = frame_i[LO_W +: PROT_W];
  assign raw  = {frame_i[PAYLOAD_W+PROT_W-1 -: HI_W], frame_i[LO_W-1:0]};

  // R9: each key nibble repaired from its own parity triple
  for (genvar g = 0; g < KEY_GROUPS; g++) begin : g_fix
    ham_fix_t fx;
    assign fx = ham_fix(raw[PAYLOAD_W-1-g*NIB_W -: NIB_W],
                        prot[PROT_W-1-g*CHK_W -: CHK_W]);
    assign payload_o[PAYLOAD_W-1-g*NIB_W -: NIB_W] = fx.nib;
    assign hit[g] = fx.hit;
  end
  assign payload_o[PAYLOAD_W-KEY_W-1:0] = raw[PAYLOAD_W-KEY_W-1:0];

  assign fix_o      = |hit;
  // R11: reserved check bits must arrive as zero
  assign resv_bad_o = |prot[RESV_W-1:0];

endmodule

// File: rtl/lnk_rx_hold.sv
module lnk_rx_hold
  import lnk_pkg::*;
#(
  parameter int unsigned PAYLOAD_W = 56
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 done_i,
  input  logic [PAYLOAD_W-1:0] payload_i,
  input  logic                 fix_i,
  input  logic                 resv_bad_i,
  input  logic                 code_err_i,
  input  logic                 link_i,
  input  logic                 read_i,
  output logic                 rdy_o,
  output logic [PAYLOAD_W-1:0] word_o,
  output logic [2:0]           stat_o
);

  logic                 rdy_d, rdy_q;
  logic                 lost_d, lost_q;
  lnk_stat_e            stat_d, stat_q;
  logic [PAYLOAD_W-1:0] word_q;
  logic                 accept, drop;

  // R7/R8: the held word only moves on a read; a frame meeting a full slot is lost
  assign accept = done_i & (~rdy_q | read_i);
  assign drop   = done_i & rdy_q & ~read_i;

  always_comb begin
    // R12: priority fatal > fixed > code error > clean
    if (lost_q || resv_bad_i) stat_d = ST_FATAL;
    else if (fix_i)           stat_d = ST_FIXED;
    else if (code_err_i)      stat_d = ST_CODE;
    else                      stat_d = ST_OK;

    rdy_d  = rdy_q;
    lost_d = lost_q;
    if (accept) begin
      rdy_d  = 1'b1;
      lost_d = 1'b0;
    end else begin
      if (read_i) rdy_d = 1'b0;
      if (drop)   lost_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      lost_q <= 1'b0;
      stat_q <= ST_OK;
    end else begin
      rdy_q  <= rdy_d;
      lost_q <= lost_d;
      if (accept) stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) word_q <= payload_i;
  end

  assign rdy_o  = rdy_q;
  assign word_o = word_q;
  // R13: with nothing held, the status shows the link state
  assign stat_o = rdy_q ? stat_q : (link_i ? ST_OK : ST_NOLINK);

endmodule

// File: rtl/lnk_word_framer.sv
module lnk_word_framer
  import lnk_pkg::*;
#(
  parameter int unsigned PAYLOAD_W = 56,
  parameter int unsigned LANE_W    = 16,
  parameter int unsigned IDLE_SYM  = 'h50BC
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_avail_i,
  input  logic [PAYLOAD_W-1:0] tx_word_i,
  output logic                 tx_take_o,
  output logic [LANE_W-1:0]    ser_txd_o,
  output logic                 ser_txen_o,
  input  logic [LANE_W-1:0]    ser_rxd_i,
  input  logic                 ser_rxdv_i,
  input  logic                 ser_rxerr_i,
  input  logic                 ser_link_i,
  output logic                 rx_rdy_o,
  output logic [PAYLOAD_W-1:0] rx_word_o,
  output logic [2:0]           rx_stat_o,
  input  logic                 rx_read_i
);

  localparam int unsigned FRAME_W = PAYLOAD_W + PROT_W;

  logic [1:0]           rs_q;
  logic                 rst_sync_n;
  logic                 asm_done, asm_err, dec_fix, dec_resv;
  logic [FRAME_W-1:0]   asm_frame;
  logic [PAYLOAD_W-1:0] dec_payload;

  // Reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  lnk_tx_seq #(.PAYLOAD_W(PAYLOAD_W), .LANE_W(LANE_W), .IDLE_SYM(IDLE_SYM)) u_tx (
    .clk(clk), .rst_n(rst_sync_n), .avail_i(tx_avail_i), .word_i(tx_word_i),
    .take_o(tx_take_o), .txd_o(ser_txd_o), .txen_o(ser_txen_o)
  );

  lnk_rx_asm #(.PAYLOAD_W(PAYLOAD_W), .LANE_W(LANE_W)) u_asm (
    .clk(clk), .rst_n(rst_sync_n), .rxd_i(ser_rxd_i), .dv_i(ser_rxdv_i),
    .err_i(ser_rxerr_i), .link_i(ser_link_i), .done_o(asm_done),
    .frame_o(asm_frame), .code_err_o(asm_err)
  );

  lnk_rx_dec #(.PAYLOAD_W(PAYLOAD_W), .LANE_W(LANE_W)) u_dec (
    .frame_i(asm_frame), .payload_o(dec_payload), .fix_o(dec_fix),
    .resv_bad_o(dec_resv)
  );

  lnk_rx_hold #(.PAYLOAD_W(PAYLOAD_W)) u_hold (
    .clk(clk), .rst_n(rst_sync_n), .done_i(asm_done), .payload_i(dec_payload),
    .fix_i(dec_fix), .resv_bad_i(dec_resv), .code_err_i(asm_err),
    .link_i(ser_link_i), .read_i(rx_read_i), .rdy_o(rx_rdy_o),
    .word_o(rx_word_o), .stat_o(rx_stat_o)
  );

endmodule

// File: rtl/lnk_word_framer_chk.sv
module lnk_word_framer_chk #(
  parameter int unsigned PAYLOAD_W = 56,
  parameter int unsigned LANE_W    = 16,
  parameter int unsigned IDLE_SYM  = 'h50BC
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tx_avail_i,
  input logic                 tx_take_o,
  input logic [LANE_W-1:0]    ser_txd_o,
  input logic                 ser_txen_o,
  input logic                 ser_link_i,
  input logic                 rx_rdy_o,
  input logic [PAYLOAD_W-1:0] rx_word_o,
  input logic [2:0]           rx_stat_o,
  input logic                 rx_read_i
);

  localparam int unsigned FRAMES = (PAYLOAD_W + 8) / LANE_W;
  localparam int unsigned RUN_W  = $clog2(FRAMES + 1) + 1;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          run_q <= '0;
    else if (ser_txen_o) run_q <= run_q + 1'b1;
    else                 run_q <= '0;
  end

  p_take_offer_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take_o |-> tx_avail_i);

  p_take_in_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take_o |-> !ser_txen_o);

  p_burst_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take_o |=> ser_txen_o);

  p_burst_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_txen_o) |-> run_q == RUN_W'(FRAMES));

  p_idle_sym_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_txen_o |-> ser_txd_o == LANE_W'(IDLE_SYM));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rdy_o && !rx_read_i |=> rx_rdy_o && $stable(rx_word_o) && $stable(rx_stat_o));

  p_nolink_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_rdy_o && !ser_link_i |-> rx_stat_o == 3'b100);

  p_stat_range_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rdy_o |-> rx_stat_o <= 3'b011);

endmodule

bind lnk_word_framer lnk_word_framer_chk #(
  .PAYLOAD_W(PAYLOAD_W), .LANE_W(LANE_W), .IDLE_SYM(IDLE_SYM)
) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .tx_avail_i(tx_avail_i), .tx_take_o(tx_take_o),
  .ser_txd_o(ser_txd_o), .ser_txen_o(ser_txen_o), .ser_link_i(ser_link_i),
  .rx_rdy_o(rx_rdy_o), .rx_word_o(rx_word_o), .rx_stat_o(rx_stat_o),
  .rx_read_i(rx_read_i)
);

// File: tb/sim_lnk_word_framer.sv
module sim_lnk_word_framer;

  localparam logic [15:0] IDLE = 16'h50BC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tx_avail = 1'b0;
  logic [55:0] tx_word = '0;
  logic        tx_take;
  logic [15:0] txd;
  logic        txen;
  logic        lb = 1'b1;
  logic [15:0] flip = '0;
  logic [15:0] b_rxd = '0;
  logic        b_dv = 1'b0;
  logic        b_err = 1'b0;
  logic        link = 1'b1;
  logic        rdy;
  logic [55:0] rword;
  logic [2:0]  rstat;
  logic        rd = 1'b0;
  logic [15:0] rxd;
  logic        rxdv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign rxd  = lb ? (txd ^ flip) : b_rxd;
  assign rxdv = lb ? txen : b_dv;

  lnk_word_framer u0 (
    .clk(clk), .rst_n(rst_n), .tx_avail_i(tx_avail), .tx_word_i(tx_word),
    .tx_take_o(tx_take), .ser_txd_o(txd), .ser_txen_o(txen),
    .ser_rxd_i(rxd), .ser_rxdv_i(rxdv), .ser_rxerr_i(b_err), .ser_link_i(link),
    .rx_rdy_o(rdy), .rx_word_o(rword), .rx_stat_o(rstat), .rx_read_i(rd)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Parity found by search: the 7-bit code word whose set positions XOR to zero
  function automatic logic [2:0] exp_par(input logic [3:0] n);
    for (int p = 0; p < 8; p++) begin
      logic [7:0] cw;
      int acc;
      cw = {n[3], n[2], n[1], p[2], n[0], p[1], p[0], 1'b0};
      acc = 0;
      for (int i = 1; i < 8; i++) if (cw[i]) acc = acc ^ i;
      if (acc == 0) return p[2:0];
    end
    return 3'b000;
  endfunction

  function automatic logic [63:0] mkframe(input logic [55:0] w, input logic [1:0] resv);
    return {w[55:48], exp_par(w[55:52]), exp_par(w[51:48]), resv, w[47:0]};
  endfunction

  function automatic logic [55:0] mkw(input int v);
    logic [31:0] a;
    logic [15:0] b;
    a = 32'(v) * 32'h9E3779B1 ^ 32'h0F1E_7788;
    b = 16'(v * 7 + 3);
    return {8'(v), b, a};
  endfunction

  task automatic do_read(input string tag);
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0; #1;
    chk(rdy == 1'b0, tag, 64'(rdy), 64'd0);
  endtask

  // Loopback: one word out through the transmitter and back through the receiver
  task automatic lb_word(input logic [55:0] w, input logic [15:0] f3, input int errf,
                         input logic [2:0] est);
    logic [63:0] cap;
    logic [63:0] ef;
    bit en_ok;
    ef = mkframe(w, 2'b00);
    @(negedge clk); #1;
    chk(tx_take == 1'b0, "R1 no take without offer", 64'(tx_take), 64'd0);
    tx_avail = 1'b1; tx_word = w; #1;
    chk(tx_take == 1'b1, "R1 take on offer while idle", 64'(tx_take), 64'd1);
    en_ok = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (k == 0) begin tx_avail = 1'b0; tx_word = ~w; end
      flip  = (k == 3) ? f3 : 16'h0;
      b_err = (k == errf);
      #1;
      cap[k*16 +: 16] = txd;
      if (!txen || tx_take) en_ok = 1'b0;
    end
    @(negedge clk); flip = '0; b_err = 1'b0; #1;
    chk(en_ok, "R2 four enabled link words", 64'(en_ok), 64'd1);
    chk(cap[47:0] == ef[47:0], "R2 data link words", cap, ef);
    chk(cap[63:48] == ef[63:48], "R3 last link word with check byte", cap, ef);
    chk(!txen && txd == IDLE, "R4 idle after frame", {47'd0, txen, txd}, {48'd0, IDLE});
    chk(rdy == 1'b1, "R5 ready after fourth word", 64'(rdy), 64'd1);
    chk(rword == w, "R5/R9 received word", 64'(rword), 64'(w));
    chk(rstat == est, "R9/R10/R11/R12 status", 64'(rstat), 64'(est));
    do_read("R7 read clears ready");
  endtask

  task automatic rx_put(input logic dv, input logic [15:0] d, input logic e);
    @(negedge clk); b_dv = dv; b_rxd = d; b_err = e;
  endtask

  task automatic rx_frames(input logic [55:0] w, input logic [1:0] resv);
    logic [63:0] f;
    f = mkframe(w, resv);
    for (int k = 0; k < 4; k++) rx_put(1'b1, f[k*16 +: 16], 1'b0);
    rx_put(1'b0, IDLE, 1'b0); #1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(!txen && txd == IDLE && !tx_take, "R4 reset idle output",
        {46'd0, tx_take, txen, txd}, {48'd0, IDLE});
    chk(!rdy && rstat == 3'b000, "R12 reset receive state", {60'd0, rdy, rstat}, 64'd0);

    // Clean sweep over every protected byte value
    for (int v = 0; v < 256; v++) lb_word(mkw(v), 16'h0, 4, 3'b000);
    // Single flips across the whole last link word
    for (int v = 0; v < 256; v++) begin
      int pos;
      pos = v % 16;
      lb_word(mkw(v * 3 + 1), 16'(1) << pos, 4, (pos < 2) ? 3'b011 : 3'b010);
    end
    // Code errors on each frame position, some with a key-bit flip as well
    for (int v = 0; v < 64; v++)
      lb_word(mkw(v + 77), (v % 8 == 0) ? 16'h0400 : 16'h0, v % 4,
              (v % 8 == 0) ? 3'b010 : 3'b001);

    // Direct receive sequences
    lb = 1'b0;
    // R6: comma after two link words drops the partial frame
    rx_put(1'b1, 16'h1111, 1'b0);
    rx_put(1'b1, 16'h2222, 1'b0);
    rx_put(1'b0, IDLE, 1'b0);
    rx_frames(56'hE1_2345_6789_ABCD, 2'b00);
    chk(rdy && rword == 56'hE1_2345_6789_ABCD && rstat == 3'b000,
        "R6 realign after comma", {5'd0, rdy, rstat, rword}, {5'd0, 1'b1, 3'b000, 56'hE1_2345_6789_ABCD});
    do_read("R7 read after realign");

    // R8: second word lost while the first waits; third word flags the loss
    rx_frames(56'h11_AAAA_BBBB_CCCC, 2'b00);
    chk(rdy && rstat == 3'b000, "R5 first word held", {60'd0, rdy, rstat}, {60'd0, 4'b1000});
    rx_frames(56'h22_DDDD_EEEE_FFFF, 2'b00);
    chk(rword == 56'h11_AAAA_BBBB_CCCC, "R8 held word not overwritten",
        64'(rword), 64'(56'h11_AAAA_BBBB_CCCC));
    chk(rstat == 3'b000, "R7 held status unchanged", 64'(rstat), 64'd0);
    do_read("R7 read first word");
    rx_frames(56'h33_0102_0304_0506, 2'b00);
    chk(rword == 56'h33_0102_0304_0506 && rstat == 3'b011, "R8 loss reported",
        {5'd0, rstat, rword}, {5'd0, 3'b011, 56'h33_0102_0304_0506});
    do_read("R7 read third word");
    rx_frames(56'h44_1234_5678_9ABC, 2'b00);
    chk(rstat == 3'b000, "R12 loss flag cleared", 64'(rstat), 64'd0);
    do_read("R7 read fourth word");

    // R11: nonzero reserved bit
    rx_frames(56'h5C_0F0F_F0F0_0000, 2'b10);
    chk(rword == 56'h5C_0F0F_F0F0_0000 && rstat == 3'b011, "R11 reserved bits set",
        {5'd0, rstat, rword}, {5'd0, 3'b011, 56'h5C_0F0F_F0F0_0000});
    do_read("R7 read reserved case");

    // R13: link down reports 100 and drops the partial frame
    @(negedge clk); link = 1'b0; #1;
    chk(!rdy && rstat == 3'b100, "R13 no link status", {60'd0, rdy, rstat}, 64'd4);
    @(negedge clk); link = 1'b1;
    rx_put(1'b1, 16'h9999, 1'b0);
    rx_put(1'b1, 16'h8888, 1'b0);
    @(negedge clk); link = 1'b0;
    @(negedge clk); link = 1'b1;
    b_dv = 1'b0;
    rx_frames(56'h7E_5555_6666_7777, 2'b00);
    chk(rdy && rword == 56'h7E_5555_6666_7777 && rstat == 3'b000, "R13 partial dropped",
        {5'd0, rdy, rstat, rword}, {5'd0, 1'b1, 3'b000, 56'h7E_5555_6666_7777});
    @(negedge clk); link = 1'b0; #1;
    chk(rstat == 3'b000, "R13 held word keeps its status", 64'(rstat), 64'd0);
    @(negedge clk); link = 1'b1;
    do_read("R7 read final word");

    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule